// File: doc/BRIEF.md
# Nibble-Mode Parallel Register Port

This block is the device end of a network adapter that hangs off a host parallel port. The host can only push one byte at a time onto an 8-bit data bus, so every register access is spread across several bytes. The top three bits of each byte carry a command, bit 4 picks the upper or lower half of a register, and the low four bits carry either a register offset or a four-bit value. The block tracks this byte stream, latches the target offset, builds up nibbles and commits them to a 16-entry, byte-wide register file. Read data returns to the host as a nibble on four of the status lines.

When no register transaction is open, pairs of command-free bytes are packed into whole bytes for the packet buffer: the low half is sent first and the high half second. The register file also holds the interrupt status and mask, the two command registers that drive the transmit and receive enables, and the address accept mode. Three event inputs from the rest of the adapter set interrupt status bits. A single interrupt line reports any enabled pending event.

Top module: `nibport_ctl`

## Requirements
- R1: After reset every register reads 0, `status_out`, `irq`, `buf_we`, `tx_en`, `rx_en` and `accept_mode` are 0.
- R2: The byte sequence end|offset (bits 7:5 = 3'b111), write-address|offset (3'b010, may repeat), write-address|value, strobe (3'b000) carrying the value, end replaces the low nibble of the register at the offset and leaves its high nibble unchanged. Bit 4 is 0 throughout the sequence.
- R3: The same sequence with bit 4 set in every byte replaces the high nibble (bits 7:4) and leaves the low nibble unchanged.
- R4: A repeated identical write-address byte does not move the latched offset. Nothing is written until a strobe byte (3'b000) arrives, so a sequence that ends without a strobe leaves the register unchanged.
- R5: After a read-address byte (3'b110, bit 4 = half, bits 3:0 = offset), `status_out[6:3]` shows the selected nibble from the next cycle on, and bits 7 and 2:0 are 0. After an end byte, `status_out` is 0 from the next cycle on.
- R6: Outside a transaction, a command-free byte with bit 4 clear stores a low nibble. A following command-free byte with bit 4 set produces one `buf_we` pulse, with `buf_byte` = {high, low}. A high byte with no pending low half produces nothing.
- R7: A 16-bit word sent as two such pairs, least significant nibble first, gives two buffer bytes: the low byte first, then the high byte.
- R8: The transmit-OK, transmit-error and receive-OK events set bits 0, 1 and 2 of the interrupt status register (offset 10). `irq` is 1 exactly when the status ANDed with the mask register (offset 11) is nonzero.
- R9: When bit 6 (the reset bit in the high nibble) of command register 1 (offset 12) is written as 1, the next clock clears the interrupt status, bits 6:4 of command register 1 and therefore `tx_en` and `rx_en`.
- R10: `tx_en` follows bit 4 and `rx_en` follows bit 5 of command register 1. `accept_mode` follows bits 5:4 of command register 2 (offset 13): 0 accepts none, 1 accepts own address, 2 accepts own address plus broadcast, 3 accepts all.
- R11: If an event arrives in the same cycle as a host write that commits to the interrupt status register, the register takes the written nibble with the event bit also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | One host byte present on `host_data` this cycle |
| host_data | input | 8 | Host byte: command 7:5, half select 4, nibble 3:0 |
| status_out | output | 8 | Status lines; read nibble on bits 6:3 |
| buf_we | output | 1 | One-cycle buffer byte strobe |
| buf_byte | output | 8 | Assembled buffer byte |
| ev_tx_ok | input | 1 | Transmit completed event |
| ev_tx_err | input | 1 | Transmit error event |
| ev_rx_ok | input | 1 | Frame received event |
| irq | output | 1 | Pending enabled interrupt |
| tx_en | output | 1 | Transmit unit enable |
| rx_en | output | 1 | Receive unit enable |
| accept_mode | output | 2 | Address accept mode |

## Verification
The interrupt status register has two writers. A host commit and an adapter event can land on the same clock edge, and the self-clearing reset of command register 1 can also coincide with an event. The bench raises the transmit-error event during exactly the cycle in which the strobe byte commits a new low nibble to the status register. It then reads the register back through the nibble read protocol and expects the written value with bit 1 forced on. It also checks that a reset write leaves the status register at zero and both enables off.

// File: rtl/nibport_pkg.sv
package nibport_pkg;
    localparam int NREGS = 16;
    localparam int DW    = 8;
    localparam int AW    = $clog2(NREGS);
    localparam int NW    = DW / 2;

    localparam logic [2:0] CMD_END = 3'b111;
    localparam logic [2:0] CMD_WA  = 3'b010;
    localparam logic [2:0] CMD_RA  = 3'b110;
    localparam logic [2:0] CMD_DAT = 3'b000;

    localparam int OFS_ISR  = 10;
    localparam int OFS_IMR  = 11;
    localparam int OFS_CMD1 = 12;
    localparam int OFS_CMD2 = 13;

    localparam int B_TXEN = 4;
    localparam int B_RXEN = 5;
    localparam int B_RST  = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WADDR,
        ST_WDONE,
        ST_RADDR
    } pst_t;
endpackage

// File: rtl/nibport_fsm.sv
module nibport_fsm
    import nibport_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic [DW-1:0] host_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          wr_hi,
    output logic [NW-1:0] wr_nib,
    output logic          rd_act,
    output logic [AW-1:0] rd_addr,
    output logic          rd_hi,
    output logic          buf_we,
    output logic [DW-1:0] buf_byte
);
    typedef struct packed {
        pst_t          st;
        logic [AW-1:0] addr;
        logic          hi;
        logic [NW-1:0] val;
        logic          vv;
        logic [NW-1:0] lo;
        logic          lov;
        logic          bwe;
        logic [DW-1:0] bbyte;
    } fsm_t;

    fsm_t q, d;
    logic          wr_c;
    logic [2:0]    cmd;
    logic          hb;
    logic [NW-1:0] nib;

    assign cmd = host_data[DW-1 -: 3];
    assign hb  = host_data[NW];
    assign nib = host_data[NW-1:0];

    always_comb begin
        d       = q;
        d.bwe   = 1'b0;
        wr_c    = 1'b0;
        if (host_wr) begin
            case (cmd)
                CMD_END: begin
                    d.st  = ST_IDLE;
                    d.vv  = 1'b0;
                    d.lov = 1'b0;
                end
                CMD_WA: begin
                    if (q.st == ST_WADDR) begin
                        d.val = nib;
                        d.vv  = 1'b1;
                    end else begin
                        d.st   = ST_WADDR;
                        d.addr = nib[AW-1:0];
                        d.hi   = hb;
                        d.vv   = 1'b0;
                        d.lov  = 1'b0;
                    end
                end
                CMD_RA: begin
                    d.st   = ST_RADDR;
                    d.addr = nib[AW-1:0];
                    d.hi   = hb;
                    d.vv   = 1'b0;
                    d.lov  = 1'b0;
                end
                CMD_DAT: begin
                    case (q.st)
                        ST_WADDR: begin
                            if (q.vv) begin
                                wr_c = 1'b1;
                                d.st = ST_WDONE;
                                d.vv = 1'b0;
                            end
                        end
                        ST_IDLE: begin
                            if (!hb) begin
                                d.lo  = nib;
                                d.lov = 1'b1;
                            end else if (q.lov) begin
                                d.bwe   = 1'b1;
                                d.bbyte = {nib, q.lo};
                                d.lov   = 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign wr_en    = wr_c;
    assign wr_addr  = q.addr;
    assign wr_hi    = q.hi;
    assign wr_nib   = q.val;
    assign rd_act   = (q.st == ST_RADDR);
    assign rd_addr  = q.addr;
    assign rd_hi    = q.hi;
    assign buf_we   = q.bwe;
    assign buf_byte = q.bbyte;

    // R6: a buffer strobe never lasts two cycles
    p_bufwe_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |=> !buf_we);

    // R2: a commit happens only on a command-free host byte
    p_commit_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (host_wr && host_data[DW-1 -: 3] == CMD_DAT));

    // R4: a repeated write-address byte never commits and keeps the offset
    p_repeat_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_data[DW-1 -: 3] == CMD_WA && q.st == ST_WADDR)
        |-> (!wr_en ##1 $stable(wr_addr)));
endmodule

// File: rtl/nibport_regfile.sv
module nibport_regfile
    import nibport_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_hi,
    input  logic [NW-1:0] wr_nib,
    input  logic          ev_tx_ok,
    input  logic          ev_tx_err,
    input  logic          ev_rx_ok,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_hi,
    output logic [NW-1:0] rd_nib,
    output logic [DW-1:0] isr,
    output logic [DW-1:0] imr,
    output logic [DW-1:0] cmd1,
    output logic [DW-1:0] cmd2
);
    typedef struct packed {
        logic [NREGS-1:0][DW-1:0] r;
    } rf_t;

    rf_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            if (wr_hi) d.r[wr_addr][DW-1:NW] = wr_nib;
            else       d.r[wr_addr][NW-1:0]  = wr_nib;
        end
        d.r[OFS_ISR][0] = d.r[OFS_ISR][0] | ev_tx_ok;
        d.r[OFS_ISR][1] = d.r[OFS_ISR][1] | ev_tx_err;
        d.r[OFS_ISR][2] = d.r[OFS_ISR][2] | ev_rx_ok;
        if (q.r[OFS_CMD1][B_RST]) begin
            d.r[OFS_ISR] = '0;
            d.r[OFS_CMD1][B_RST:B_TXEN] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_nib = rd_hi ? q.r[rd_addr][DW-1:NW] : q.r[rd_addr][NW-1:0];
    assign isr    = q.r[OFS_ISR];
    assign imr    = q.r[OFS_IMR];
    assign cmd1   = q.r[OFS_CMD1];
    assign cmd2   = q.r[OFS_CMD2];

    // R9: the reset bit clears status and enables one clock later
    p_reset_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd1[B_RST] && !wr_en) |=> (isr == '0 && cmd1[B_RST:B_TXEN] == '0));

    // R8: a receive event is recorded unless a clear is pending
    p_event_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_ok && !cmd1[B_RST]) |=> isr[2]);

    // R11: an event wins over a simultaneous host write of the status register
    p_event_vs_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_err && wr_en && wr_addr == AW'(OFS_ISR) && !cmd1[B_RST]) |=> isr[1]);
endmodule

// File: rtl/nibport_ctl.sv
module nibport_ctl
    import nibport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic [7:0] host_data,
    output logic [7:0] status_out,
    output logic       buf_we,
    output logic [7:0] buf_byte,
    input  logic       ev_tx_ok,
    input  logic       ev_tx_err,
    input  logic       ev_rx_ok,
    output logic       irq,
    output logic       tx_en,
    output logic       rx_en,
    output logic [1:0] accept_mode
);
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic          wr_hi;
    logic [NW-1:0] wr_nib;
    logic          rd_act;
    logic [AW-1:0] rd_addr;
    logic          rd_hi;
    logic [NW-1:0] rd_nib;
    logic [DW-1:0] isr, imr, cmd1, cmd2;

    nibport_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_wr  (host_wr),
        .host_data(host_data),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_hi    (wr_hi),
        .wr_nib   (wr_nib),
        .rd_act   (rd_act),
        .rd_addr  (rd_addr),
        .rd_hi    (rd_hi),
        .buf_we   (buf_we),
        .buf_byte (buf_byte)
    );

    nibport_regfile u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_hi    (wr_hi),
        .wr_nib   (wr_nib),
        .ev_tx_ok (ev_tx_ok),
        .ev_tx_err(ev_tx_err),
        .ev_rx_ok (ev_rx_ok),
        .rd_addr  (rd_addr),
        .rd_hi    (rd_hi),
        .rd_nib   (rd_nib),
        .isr      (isr),
        .imr      (imr),
        .cmd1     (cmd1),
        .cmd2     (cmd2)
    );

    assign status_out  = rd_act ? {1'b0, rd_nib, 3'b000} : 8'h00;
    assign irq         = |(isr & imr);
    assign tx_en       = cmd1[B_TXEN];
    assign rx_en       = cmd1[B_RXEN];
    assign accept_mode = cmd2[B_RXEN:B_TXEN];

    // R5: an end byte drops the status lines on the next cycle
    p_end_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_data[7:5] == CMD_END) |=> (status_out == 8'h00));
endmodule

// File: tb/sim_nibport_ctl.sv
module sim_nibport_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic [7:0] status_out;
    logic       buf_we;
    logic [7:0] buf_byte;
    logic       ev_tx_ok = 1'b0, ev_tx_err = 1'b0, ev_rx_ok = 1'b0;
    logic       irq, tx_en, rx_en;
    logic [1:0] accept_mode;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    nibport_ctl u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_data(host_data),
        .status_out(status_out), .buf_we(buf_we), .buf_byte(buf_byte),
        .ev_tx_ok(ev_tx_ok), .ev_tx_err(ev_tx_err), .ev_rx_ok(ev_rx_ok),
        .irq(irq), .tx_en(tx_en), .rx_en(rx_en), .accept_mode(accept_mode)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        host_data = b;
        host_wr   = 1'b1;
        @(negedge clk);
        host_wr   = 1'b0;
    endtask

    task automatic wr_nib(input logic [3:0] a, input logic hi, input logic [3:0] v,
                          input logic with_ev);
        logic [7:0] h;
        h = hi ? 8'h10 : 8'h00;
        send(8'hE0 | h | a);
        send(8'h40 | h | a);
        send(8'h40 | h | a);
        send(8'h40 | h | v);
        if (with_ev) ev_tx_err = 1'b1;
        send(h | v);
        ev_tx_err = 1'b0;
        send(h | v);
        send(8'hE0 | h | v);
    endtask

    task automatic rd_nib(input logic [3:0] a, input logic hi, output logic [3:0] v,
                          output logic [7:0] raw);
        logic [7:0] h;
        h = hi ? 8'h10 : 8'h00;
        send(8'hE0 | h | a);
        send(8'hC0 | h | a);
        raw = status_out;
        v   = status_out[6:3];
        send(8'hE0 | h | a);
    endtask

    task automatic push_pair(input logic [7:0] b);
        exp_q.push_back(b);
        send({4'h0, b[3:0]});
        send({4'h1, b[7:4]});
    endtask

    task automatic pulse(input int which);
        case (which)
            0: ev_tx_ok = 1'b1;
            1: ev_tx_err = 1'b1;
            default: ev_rx_ok = 1'b1;
        endcase
        @(negedge clk);
        ev_tx_ok = 1'b0; ev_tx_err = 1'b0; ev_rx_ok = 1'b0;
    endtask

    // monitor: pops expected buffer bytes as the design emits them
    always @(negedge clk) begin
        if (rst_n && buf_we) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R6: actual %h expected no byte", buf_byte);
            end else begin
                chk("R6/R7 buffer byte", buf_byte, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] v;
        logic [7:0] raw;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", status_out, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 buf_we", {7'd0, buf_we}, 8'h00);
        chk("R1 enables", {5'd0, accept_mode, tx_en}, 8'h00);
        rd_nib(4'd0, 1'b0, v, raw);
        chk("R1 reg0", {4'd0, v}, 8'h00);

        // R2 low nibble write
        wr_nib(4'd3, 1'b0, 4'hA, 1'b0);
        rd_nib(4'd3, 1'b0, v, raw);
        chk("R2 low", {4'd0, v}, 8'h0A);
        chk("R5 status framing", raw & 8'h87, 8'h00);
        chk("R5 after end", status_out, 8'h00);
        rd_nib(4'd3, 1'b1, v, raw);
        chk("R2 high untouched", {4'd0, v}, 8'h00);

        // R3 high nibble write
        wr_nib(4'd3, 1'b1, 4'h5, 1'b0);
        rd_nib(4'd3, 1'b1, v, raw);
        chk("R3 high", {4'd0, v}, 8'h05);
        rd_nib(4'd3, 1'b0, v, raw);
        chk("R3 low kept", {4'd0, v}, 8'h0A);

        // R4 repeated address with no strobe
        send(8'hE7); send(8'h47); send(8'h47); send(8'h47); send(8'h4C); send(8'hE7);
        rd_nib(4'd7, 1'b0, v, raw);
        chk("R4 no strobe no write", {4'd0, v}, 8'h00);
        // R4 offset 5 written with value equal to offset
        wr_nib(4'd5, 1'b0, 4'h5, 1'b0);
        rd_nib(4'd5, 1'b0, v, raw);
        chk("R4 value equals offset", {4'd0, v}, 8'h05);

        // R6 buffer pairs, orphan high half
        push_pair(8'hAC);
        push_pair(8'h3F);
        send(8'h15);
        @(negedge clk);
        // R7 word 0x1234: low byte first
        push_pair(8'h34);
        push_pair(8'h12);
        @(negedge clk);
        chk("R7 queue drained", 8'(exp_q.size()), 8'h00);

        // R10 enables and accept mode
        wr_nib(4'd12, 1'b1, 4'h3, 1'b0);
        chk("R10 tx_en", {7'd0, tx_en}, 8'h01);
        chk("R10 rx_en", {7'd0, rx_en}, 8'h01);
        wr_nib(4'd13, 1'b1, 4'h2, 1'b0);
        chk("R10 accept", {6'd0, accept_mode}, 8'h02);

        // R8 events and mask
        wr_nib(4'd11, 1'b0, 4'h4, 1'b0);
        chk("R8 irq idle", {7'd0, irq}, 8'h00);
        pulse(2);
        chk("R8 irq on rx", {7'd0, irq}, 8'h01);
        pulse(0);
        rd_nib(4'd10, 1'b0, v, raw);
        chk("R8 isr bits", {4'd0, v}, 8'h05);
        wr_nib(4'd11, 1'b0, 4'h0, 1'b0);
        chk("R8 irq masked", {7'd0, irq}, 8'h00);

        // R9 reset bit
        wr_nib(4'd12, 1'b1, 4'h7, 1'b0);
        chk("R9 tx_en cleared", {7'd0, tx_en}, 8'h00);
        chk("R9 rx_en cleared", {7'd0, rx_en}, 8'h00);
        rd_nib(4'd10, 1'b0, v, raw);
        chk("R9 isr cleared", {4'd0, v}, 8'h00);
        rd_nib(4'd12, 1'b1, v, raw);
        chk("R9 reset bit self clears", {4'd0, v}, 8'h00);

        // R11 event in the commit cycle
        wr_nib(4'd10, 1'b0, 4'h1, 1'b1);
        rd_nib(4'd10, 1'b0, v, raw);
        chk("R11 write plus event", {4'd0, v}, 8'h03);
        wr_nib(4'd11, 1'b0, 4'h2, 1'b0);
        chk("R11 irq from event bit", {7'd0, irq}, 8'h01);

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule